// File: doc/BRIEF.md
# Keyed Write Gate for a Watchdog Register Window

This block sits in front of the protected registers of a small 16-byte memory-mapped watchdog window. Every write transaction arrives with a 4-bit byte offset, a transfer size and up to 32 bits of data. Writes that change timer preloads, restart the countdown or clear the reboot status flag pass only after software has written a two-value key to the kick offset (0x0C). The gate then admits exactly one halfword or word write and locks again.

The gate turns an admitted write into single-cycle strobes toward the watchdog core: a load strobe for each of the two preload registers, with the 20-bit value to load; a reload (kick) pulse; and a pulse that clears the core's previous-reboot flag. In the other direction it answers reads of the kick offset with that flag, mirrored onto two bit positions, so that software checking either position sees it. The countdown timer itself lives in the core.

Transfer sizes are encoded on `wr_size`/`rd_size` as 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 reserved. Data compared against key values, or decoded for control bits, is taken zero-extended from the transfer size: the low 8 bits for a byte and the low 16 bits for a halfword.

Top module: `ukg_unlock_gate`

## Requirements
- R1: After synchronous active-low reset the gate is locked, all four strobes are low, `preload_val` is 0 and `rd_data` is 0. A partly entered or completed key does not survive reset.
- R2: A byte, halfword or word write of value 0x80 to offset 0x0C arms the gate from any state (locked, armed or open).
- R3: A write of value 0x86 to offset 0x0C opens the gate only when it is armed. In the locked state it has no effect.
- R4: In the open state a word write to offset 0x00 raises `load_a` for one cycle, and `preload_val` takes bits [19:0] of the data.
- R5: In the open state a word write to offset 0x04 raises `load_b` for one cycle, and `preload_val` takes bits [19:0] of the data.
- R6: In the open state a halfword write to offset 0x0C with bit 8 set raises `reload_pulse` for one cycle. A word write to 0x0C never raises it.
- R7: In the open state a halfword write to offset 0x0C with bit 9 or bit 12 set raises `flag_clr_pulse` for one cycle. It may coincide with `reload_pulse`.
- R8: In the open state, any halfword or word write that is not the 0x80 key locks the gate. This holds whether or not the write hit a protected register, so each unlock admits at most one protected write.
- R9: Byte writes and reserved-size (2'b11) writes never raise a strobe, and they do not use up an open gate. Byte writes still take part in the key sequence.
- R10: While the gate is locked or armed, writes to protected offsets raise no strobe, and a non-key write leaves an armed gate armed.
- R11: A halfword read of offset 0x0C returns `reboot_flag` on both bit 9 and bit 12. Every other read, and every cycle without a read, gives 0 on `rd_data`.
- R12: Strobes and `rd_data` are registered. Each appears in the cycle after the clock edge that accepted the transaction, and no strobe is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write transaction valid this cycle |
| wr_addr | input | ADDR_W (4) | Write byte offset |
| wr_size | input | 2 | Write size: 00 byte, 01 half, 10 word, 11 reserved |
| wr_data | input | DATA_W (32) | Write data, right-aligned |
| rd_en | input | 1 | Read transaction valid this cycle |
| rd_addr | input | ADDR_W (4) | Read byte offset |
| rd_size | input | 2 | Read size, same encoding as wr_size |
| rd_data | output | DATA_W (32) | Read data, valid the cycle after rd_en |
| reboot_flag | input | 1 | Previous-reboot flag held by the watchdog core |
| load_a | output | 1 | Load strobe for the first-stage preload |
| load_b | output | 1 | Load strobe for the second-stage preload |
| preload_val | output | PRELOAD_W (20) | Value for the preload being loaded |
| reload_pulse | output | 1 | Restart-countdown pulse |
| flag_clr_pulse | output | 1 | Clear pulse for the previous-reboot flag |

## Verification
Each result of this block comes one clock edge after the edge that accepts its transaction. A write strobe or `preload_val` update appears in the cycle after the write, and read data in the cycle after the read. Key state changes at the same edge and governs the very next write. The bench drives each transaction on a falling edge and holds it for exactly one cycle. It samples outputs on the following falling edge, after the single capturing rising edge. Every vector therefore sees only the effect of its own write and the key state that the earlier vectors left behind.

// File: rtl/ukg_pkg.sv
// Shared types for the keyed write gate.
// Assumes a byte-addressed window with transfers right-aligned on the data bus.
package ukg_pkg;

    // Transfer size encoding on the write and read request ports.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    // Key sequencer states; the order is the unlock order.
    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_state_e;

    // Strobes toward the watchdog core.
    typedef struct packed {
        logic load_a;
        logic load_b;
        logic reload;
        logic flag_clr;
    } core_strobe_t;

endpackage

// File: rtl/ukg_xfer_decode.sv
// Write-transfer decoder.
// Zero-extends the data from the transfer size and flags the two key
// values at the kick offset. Purely combinational.
// Assumes DATA_W >= 16 and that the reserved size never matches a key.
module ukg_xfer_decode
    import ukg_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] OFF_KICK = ADDR_W'(12),
    parameter logic [7:0]        KEY_ARM  = 8'h80,
    parameter logic [7:0]        KEY_OPEN = 8'h86
) (
    input  logic [ADDR_W-1:0] addr,
    input  xfer_size_e        size,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] eff,
    output logic              hit_arm,
    output logic              hit_open,
    output logic              is_wide
);
    localparam logic [DATA_W-1:0] ARM_EXT  = {{(DATA_W-8){1'b0}}, KEY_ARM};
    localparam logic [DATA_W-1:0] OPEN_EXT = {{(DATA_W-8){1'b0}}, KEY_OPEN};

    logic at_kick;
    logic size_ok;

    // Size-dependent zero extension of the written value.
    always_comb begin
        eff = '0;
        unique case (size)
            SZ_BYTE: eff[7:0]  = data[7:0];
            SZ_HALF: eff[15:0] = data[15:0];
            SZ_WORD: eff       = data;
            default: eff       = '0;
        endcase
    end

    // Key matches and transfer classification.
    always_comb begin
        at_kick  = (addr == OFF_KICK);
        size_ok  = (size != SZ_RSVD);
        hit_arm  = at_kick && size_ok && (eff == ARM_EXT);
        hit_open = at_kick && size_ok && (eff == OPEN_EXT);
        is_wide  = (size == SZ_HALF) || (size == SZ_WORD);
    end

endmodule

// File: rtl/ukg_key_seq.sv
// Key sequencer: locked -> armed -> open.
// The arm key re-arms from any state. The open key only advances an armed gate.
// An open gate is used up by any halfword or word write other than the arm key.
// Assumes hit_arm/hit_open/is_wide describe the write presented this cycle.
module ukg_key_seq
    import ukg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        hit_arm,
    input  logic        hit_open,
    input  logic        is_wide,
    output gate_state_e gate_q
);
    gate_state_e gate_d;

    // Next-state selection; priority follows the key order.
    always_comb begin
        gate_d = gate_q;
        if (wr_en) begin
            if (hit_arm)
                gate_d = GATE_ARMED;
            else if (hit_open && gate_q == GATE_ARMED)
                gate_d = GATE_OPEN;
            else if (gate_q == GATE_OPEN && is_wide)
                gate_d = GATE_LOCKED;
        end
    end

    // State register with synchronous reset to locked.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= GATE_LOCKED;
        else        gate_q <= gate_d;
    end

endmodule

// File: rtl/ukg_prot_write.sv
// Protected-write stage.
// Turns the single write admitted by an open gate into registered one-cycle
// strobes, and holds the last preload value.
// Assumes eff is already zero-extended from the transfer size and that
// PRELOAD_W exceeds every control bit index used here.
module ukg_prot_write
    import ukg_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 32,
    parameter int                PRELOAD_W   = 20,
    parameter logic [ADDR_W-1:0] OFF_PRE_A   = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] OFF_PRE_B   = ADDR_W'(4),
    parameter logic [ADDR_W-1:0] OFF_KICK    = ADDR_W'(12),
    parameter int                BIT_KICK    = 8,
    parameter int                BIT_FLAG_LO = 9,
    parameter int                BIT_FLAG_HI = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  gate_state_e          gate_q,
    input  logic [ADDR_W-1:0]    addr,
    input  xfer_size_e           size,
    input  logic [DATA_W-1:0]    eff,
    input  logic                 hit_arm,
    input  logic                 is_wide,
    output core_strobe_t         stb_q,
    output logic [PRELOAD_W-1:0] preload_q
);
    logic         grant;
    logic         word_ok;
    logic         half_kick;
    core_strobe_t stb_d;
    logic         unused_hi;

    assign unused_hi = ^eff[DATA_W-1:PRELOAD_W];

    // Admission: the one non-key wide write accepted while open.
    always_comb begin
        grant     = wr_en && (gate_q == GATE_OPEN) && !hit_arm && is_wide;
        word_ok   = grant && (size == SZ_WORD);
        half_kick = grant && (size == SZ_HALF) && (addr == OFF_KICK);
    end

    // Target decode for the admitted write.
    always_comb begin
        stb_d.load_a   = word_ok && (addr == OFF_PRE_A);
        stb_d.load_b   = word_ok && (addr == OFF_PRE_B);
        stb_d.reload   = half_kick && eff[BIT_KICK];
        stb_d.flag_clr = half_kick && (eff[BIT_FLAG_LO] || eff[BIT_FLAG_HI]);
    end

    // Strobe register: one cycle per admitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= '0;
        else        stb_q <= stb_d;
    end

    // Preload value register: updated only by a preload load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            preload_q <= '0;
        else if (stb_d.load_a || stb_d.load_b)
            preload_q <= eff[PRELOAD_W-1:0];
    end

endmodule

// File: rtl/ukg_status_read.sv
// Status read path.
// A halfword read of the kick offset returns the reboot flag on two bit
// positions. Any other read, or no read, returns zero. The output is registered.
module ukg_status_read
    import ukg_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] OFF_KICK    = ADDR_W'(12),
    parameter int                BIT_FLAG_LO = 9,
    parameter int                BIT_FLAG_HI = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  xfer_size_e        rd_size,
    input  logic              flag,
    output logic [DATA_W-1:0] rd_data_q
);
    logic [DATA_W-1:0] rd_d;

    // Build the status word for a qualifying read.
    always_comb begin
        rd_d = '0;
        if (rd_en && rd_size == SZ_HALF && rd_addr == OFF_KICK) begin
            rd_d[BIT_FLAG_LO] = flag;
            rd_d[BIT_FLAG_HI] = flag;
        end
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_d;
    end

endmodule

// File: rtl/ukg_unlock_gate.sv
// Keyed write gate, top level.
// Connects the decoder, key sequencer, protected-write stage and status read
// path. Assumes one write and/or one read per cycle, with no back-pressure.
module ukg_unlock_gate
    import ukg_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 32,
    parameter int                PRELOAD_W   = 20,
    parameter logic [ADDR_W-1:0] OFF_PRE_A   = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] OFF_PRE_B   = ADDR_W'(4),
    parameter logic [ADDR_W-1:0] OFF_KICK    = ADDR_W'(12),
    parameter logic [7:0]        KEY_ARM     = 8'h80,
    parameter logic [7:0]        KEY_OPEN    = 8'h86,
    parameter int                BIT_KICK    = 8,
    parameter int                BIT_FLAG_LO = 9,
    parameter int                BIT_FLAG_HI = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [1:0]           wr_size,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [1:0]           rd_size,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 reboot_flag,
    output logic                 load_a,
    output logic                 load_b,
    output logic [PRELOAD_W-1:0] preload_val,
    output logic                 reload_pulse,
    output logic                 flag_clr_pulse
);
    xfer_size_e        wsz;
    xfer_size_e        rsz;
    logic [DATA_W-1:0] eff;
    logic              hit_arm;
    logic              hit_open;
    logic              is_wide;
    gate_state_e       gate_q;
    core_strobe_t      stb_q;

    assign wsz = xfer_size_e'(wr_size);
    assign rsz = xfer_size_e'(rd_size);

    ukg_xfer_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_KICK(OFF_KICK),
        .KEY_ARM(KEY_ARM), .KEY_OPEN(KEY_OPEN)
    ) u_dec (
        .addr(wr_addr), .size(wsz), .data(wr_data), .eff(eff),
        .hit_arm(hit_arm), .hit_open(hit_open), .is_wide(is_wide)
    );

    ukg_key_seq u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hit_arm(hit_arm),
        .hit_open(hit_open), .is_wide(is_wide), .gate_q(gate_q)
    );

    ukg_prot_write #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRELOAD_W(PRELOAD_W),
        .OFF_PRE_A(OFF_PRE_A), .OFF_PRE_B(OFF_PRE_B), .OFF_KICK(OFF_KICK),
        .BIT_KICK(BIT_KICK), .BIT_FLAG_LO(BIT_FLAG_LO), .BIT_FLAG_HI(BIT_FLAG_HI)
    ) u_pw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .gate_q(gate_q),
        .addr(wr_addr), .size(wsz), .eff(eff), .hit_arm(hit_arm),
        .is_wide(is_wide), .stb_q(stb_q), .preload_q(preload_val)
    );

    ukg_status_read #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_KICK(OFF_KICK),
        .BIT_FLAG_LO(BIT_FLAG_LO), .BIT_FLAG_HI(BIT_FLAG_HI)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_size(rsz), .flag(reboot_flag), .rd_data_q(rd_data)
    );

    assign load_a         = stb_q.load_a;
    assign load_b         = stb_q.load_b;
    assign reload_pulse   = stb_q.reload;
    assign flag_clr_pulse = stb_q.flag_clr;

endmodule

// File: rtl/ukg_checker.sv
// Property checker for the keyed write gate, bound to every instance of the top.
module ukg_checker
    import ukg_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] OFF_KICK    = ADDR_W'(12),
    parameter int                BIT_FLAG_LO = 9,
    parameter int                BIT_FLAG_HI = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_size,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        gate,
    input logic [3:0]        stb,
    input logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] FLAG_MASK =
        (DATA_W'(1) << BIT_FLAG_LO) | (DATA_W'(1) << BIT_FLAG_HI);

    // Reset leaves the gate locked with no strobes.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (gate == GATE_LOCKED && stb == 4'b0));

    // A word write of the arm key arms the gate.
    assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFF_KICK && wr_size == SZ_WORD && wr_data == DATA_W'(8'h80))
        |=> gate == GATE_ARMED);

    // The gate only opens from the armed state.
    assert_open_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate == GATE_OPEN && $past(gate) != GATE_OPEN) |-> $past(gate) == GATE_ARMED);

    // Preload loads are mutually exclusive with each other and with kick-offset pulses.
    assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb[3], stb[2], stb[1] | stb[0]}));

    // A strobe consumes the unlock.
    assert_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb != 4'b0) |-> gate == GATE_LOCKED);

    // A byte write never strobes.
    assert_byte_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_BYTE) |=> stb == 4'b0);

    // A strobe needs an open gate on the accepting edge.
    assert_needs_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stb != 4'b0) |-> $past(gate) == GATE_OPEN);

    // Read data only ever carries the two flag bits, always equal.
    assert_read_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & ~FLAG_MASK) == '0) && (rd_data[BIT_FLAG_LO] == rd_data[BIT_FLAG_HI]));

    // No strobe lasts two cycles.
    assert_single_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (stb != 4'b0) |=> stb == 4'b0);

endmodule

bind ukg_unlock_gate ukg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_KICK(OFF_KICK),
    .BIT_FLAG_LO(BIT_FLAG_LO), .BIT_FLAG_HI(BIT_FLAG_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .gate(gate_q),
    .stb({load_a, load_b, reload_pulse, flag_clr_pulse}), .rd_data(rd_data)
);

// File: tb/sim_ukg_unlock_gate.sv
module sim_ukg_unlock_gate;
    // Vector fields: req[65:62] size[61:60] addr[59:56] data[55:24]
    // expected strobes {load_a,load_b,reload,flag_clr}[23:20] expected preload[19:0]
    localparam int NV = 56;
    localparam logic [1:0] B = 2'd0, H = 2'd1, W = 2'd2, X = 2'd3;
    localparam logic [65:0] VEC [NV] = '{
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},     // R2 arm (byte)
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},     // R3 open
        {4'd4,  W, 4'h0, 32'hFFF12345, 4'b1000, 20'h12345}, // R4 low 20 bits kept
        {4'd10, W, 4'h4, 32'h000ABCDE, 4'b0000, 20'h0},     // R10 locked again
        {4'd2,  H, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  H, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd5,  W, 4'h4, 32'h000ABCDE, 4'b0100, 20'hABCDE}, // R5
        {4'd2,  W, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  W, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd6,  H, 4'hC, 32'h00000100, 4'b0010, 20'h0},     // R6 kick
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd7,  H, 4'hC, 32'h00000200, 4'b0001, 20'h0},     // R7 bit 9
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd7,  H, 4'hC, 32'h00001000, 4'b0001, 20'h0},     // R7 bit 12
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd6,  H, 4'hC, 32'h00001300, 4'b0011, 20'h0},     // R6 with R7 together
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd9,  B, 4'h0, 32'h00000055, 4'b0000, 20'h0},     // R9 byte ignored
        {4'd9,  B, 4'hC, 32'h00000100, 4'b0000, 20'h0},     // R9 byte to kick offset
        {4'd9,  W, 4'h0, 32'h00000077, 4'b1000, 20'h00077}, // R9 gate still open
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd8,  H, 4'h8, 32'h00001234, 4'b0000, 20'h0},     // R8 unprotected hit
        {4'd8,  W, 4'h0, 32'h00000001, 4'b0000, 20'h0},     // R8 already used
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},     // R3 open key while locked
        {4'd10, W, 4'h0, 32'h00000005, 4'b0000, 20'h0},
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},     // R2 re-arm while armed
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd5,  W, 4'h4, 32'h00000009, 4'b0100, 20'h00009},
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},     // R2 arm from open
        {4'd10, W, 4'h0, 32'h00000003, 4'b0000, 20'h0},     // R10 armed, no strobe
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},     // R10 stayed armed
        {4'd4,  W, 4'h0, 32'h00000003, 4'b1000, 20'h00003},
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd9,  X, 4'h0, 32'h00000007, 4'b0000, 20'h0},     // R9 reserved size
        {4'd4,  W, 4'h0, 32'h00000007, 4'b1000, 20'h00007},
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd8,  H, 4'h0, 32'h00012345, 4'b0000, 20'h0},     // R8 half to preload offset
        {4'd8,  W, 4'h0, 32'h00000001, 4'b0000, 20'h0},
        {4'd2,  B, 4'hC, 32'h00000080, 4'b0000, 20'h0},
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd6,  W, 4'hC, 32'h00000100, 4'b0000, 20'h0},     // R6 word never kicks
        {4'd10, H, 4'hC, 32'h00000100, 4'b0000, 20'h0},
        {4'd10, H, 4'hC, 32'h00001300, 4'b0000, 20'h0},
        {4'd2,  H, 4'hC, 32'h00000180, 4'b0000, 20'h0},     // R2 wrong key value
        {4'd3,  B, 4'hC, 32'h00000086, 4'b0000, 20'h0},
        {4'd10, W, 4'h0, 32'h00000001, 4'b0000, 20'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [1:0]  rd_size = '0;
    logic [31:0] rd_data;
    logic        reboot_flag = 1'b0;
    logic        load_a, load_b, reload_pulse, flag_clr_pulse;
    logic [19:0] preload_val;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ukg_unlock_gate u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_size(rd_size), .rd_data(rd_data), .reboot_flag(reboot_flag),
        .load_a(load_a), .load_b(load_b), .preload_val(preload_val),
        .reload_pulse(reload_pulse), .flag_clr_pulse(flag_clr_pulse)
    );

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One write, driven on a falling edge; results sampled one edge later.
    task automatic wr(input logic [1:0] sz, input logic [3:0] a, input logic [31:0] d);
        wr_size = sz; wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sz, input logic [3:0] a);
        rd_size = sz; rd_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] stbs();
        return {28'b0, load_a, load_b, reload_pulse, flag_clr_pulse};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(1, stbs(), 32'h0, "strobes after reset");
        chk(1, {12'b0, preload_val}, 32'h0, "preload after reset");
        chk(1, rd_data, 32'h0, "rd_data after reset");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [65:0] v;
            v = VEC[i];
            wr(v[61:60], v[59:56], v[55:24]);
            chk(int'(v[65:62]), stbs(), {28'b0, v[23:20]}, $sformatf("vector %0d strobes", i));
            if (v[23] || v[22])
                chk(int'(v[65:62]), {12'b0, preload_val}, {12'b0, v[19:0]},
                    $sformatf("vector %0d preload", i));
        end

        // R12: strobe gone one cycle after
        wr(B, 4'hC, 32'h80); wr(B, 4'hC, 32'h86); wr(W, 4'h4, 32'h11);
        @(negedge clk);
        chk(12, stbs(), 32'h0, "strobe lasted one cycle");

        // R11: status reads
        reboot_flag = 1'b1;
        rd(H, 4'hC); chk(11, rd_data, 32'h00001200, "flag mirrored on bits 9 and 12");
        @(negedge clk); chk(11, rd_data, 32'h0, "no read gives zero");
        rd(B, 4'hC); chk(11, rd_data, 32'h0, "byte read");
        rd(W, 4'hC); chk(11, rd_data, 32'h0, "word read");
        rd(H, 4'h8); chk(11, rd_data, 32'h0, "other offset");
        reboot_flag = 1'b0;
        rd(H, 4'hC); chk(11, rd_data, 32'h0, "flag clear");

        // R1: reset drops a completed key
        wr(B, 4'hC, 32'h80); wr(B, 4'hC, 32'h86);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(1, {12'b0, preload_val}, 32'h0, "preload cleared by reset");
        wr(W, 4'h0, 32'h9);
        chk(1, stbs(), 32'h0, "key lost across reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule